// File: doc/BRIEF.md
# Receive Packet FIFO with Per-Packet Status

This block sits between a network receive path and a host. The network side pushes received bytes one per cycle, marking the first and last byte of each packet and supplying a four-bit error code with the last byte. The block stores the bytes in a ring buffer and keeps one status entry for each packet that has been fully received. It can hold at most eight such packets.

The host side always sees the oldest complete packet, the top packet. It sees a status word with the packet's error code and the number of its bytes not yet read. The next data byte of that packet is shown on a read-data output, and each read strobe consumes one byte. A discard strobe drops whatever is left of the top packet and moves on to the next one. A diagnostic word reports four conditions: a packet is being received, the status slots are full, the byte storage is full, or the host read past the end of the data. The last of these is fatal. It drives an adapter-failure output until a receiver reset or a global reset clears it.

Top module: `rx_pkt_fifo`

## Requirements
- R1: With no complete packet stored, `status_o` reads 16'h8000. Otherwise bit 15 is 0, bits 14..11 carry the top packet's error code, and bits 10..0 give the count of its bytes not yet read.
- R2: `rd_data_o` shows the top packet's next unread byte. Bytes come out in arrival order, and each `rd_en_i` pulse (without `discard_i`) consumes one byte and lowers the status count by one.
- R3: The error code given with a packet's last byte is reported unchanged in status bits 14..11. Codes 1000, 1001, 1011, 1100 and 1101 have bit 14 set and mark an error, and 0010 marks dribble bits.
- R4: A packet whose first byte arrives while eight complete packets are stored is refused and not stored. Diagnostic bit 12 sets, and it clears on the next discard.
- R5: A byte that arrives while the byte storage is full causes its packet to be dropped entirely, including bytes already written, with no status entry. Diagnostic bit 11 sets, and further packets are refused while it is set. It clears when the host reads or discards bytes.
- R6: A read with no unread byte in the top packet, or with no packet stored, sets diagnostic bit 13 and `adapter_fail_o`. Both stay set until `rx_reset_i` or `rst_ni`.
- R7: `discard_i` removes the top packet, read or not, so the next stored packet becomes the top. A discard with no packet stored has no effect.
- R8: `rx_complete_o` is high exactly when at least one complete packet is stored.
- R9: `rx_reset_i` empties all packet and byte storage and clears every diagnostic flag on the next clock edge.
- R10: Diagnostic bit 15 is high from the clock after an accepted first byte until the clock that takes the last byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low global reset |
| net_valid_i | input | 1 | Network byte valid |
| net_byte_i | input | 8 | Network data byte |
| net_sop_i | input | 1 | First byte of packet |
| net_eop_i | input | 1 | Last byte of packet |
| net_err_i | input | 4 | Error code, sampled with the last byte |
| rd_en_i | input | 1 | Host consumes one byte of top packet |
| discard_i | input | 1 | Drop remainder of top packet |
| rx_reset_i | input | 1 | Synchronous receiver reset |
| rd_data_o | output | 8 | Next byte of top packet |
| status_o | output | 16 | Top packet status word |
| diag_o | output | 16 | Diagnostic flags (15 receiving, 13 underrun, 12 status overrun, 11 byte overrun) |
| rx_complete_o | output | 1 | At least one complete packet stored |
| adapter_fail_o | output | 1 | Fatal underrun occurred |

## Verification
Single packets with clean and error codes show that the status word carries the code and a count that falls with each read. Two back-to-back packets with a partial read followed by a discard show that the read pointer skips exactly the unread remainder. Nine short packets fill the status slots, and a 1500-byte packet followed by a 600-byte one overflows byte storage. These two overflows are told apart by which diagnostic bit rises and by what clears it, and later discards show that the refused packets left no trace. Reads on an empty FIFO and past a packet's end separate the sticky failure from the self-clearing overruns.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int LEN_W  = 11;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_RECV = 2'd1,
    RX_DROP = 2'd2
  } rx_state_e;

  localparam int DG_RECV = 15;
  localparam int DG_UND  = 13;
  localparam int DG_SOVR = 12;
  localparam int DG_OVR  = 11;
endpackage

// File: rtl/rxf_byte_ram.sv
module rxf_byte_ram #(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/rxf_pkt_queue.sv
module rxf_pkt_queue #(
  parameter int SLOTS  = 8,
  parameter int LEN_W  = 11,
  parameter int CODE_W = 4,
  parameter int CW     = $clog2(SLOTS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [LEN_W-1:0]  push_len_i,
  input  logic [CODE_W-1:0] push_code_i,
  input  logic              pop_i,
  output logic [CW-1:0]     count_o,
  output logic [LEN_W-1:0]  top_len_o,
  output logic [CODE_W-1:0] top_code_o
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [LEN_W-1:0]  len_mem  [SLOTS];
  logic [CODE_W-1:0] code_mem [SLOTS];
  logic [IW-1:0]     head_q, tail_q;
  logic [CW-1:0]     cnt_q;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] p);
    return (p == IW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      len_mem[tail_q]  <= push_len_i;
      code_mem[tail_q] <= push_code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign count_o    = cnt_q;
  assign top_len_o  = len_mem[head_q];
  assign top_code_o = code_mem[head_q];
endmodule

// File: rtl/rx_pkt_fifo.sv
module rx_pkt_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int SLOTS = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        net_valid_i,
  input  logic [7:0]  net_byte_i,
  input  logic        net_sop_i,
  input  logic        net_eop_i,
  input  logic [3:0]  net_err_i,
  input  logic        rd_en_i,
  input  logic        discard_i,
  input  logic        rx_reset_i,
  output logic [7:0]  rd_data_o,
  output logic [15:0] status_o,
  output logic [15:0] diag_o,
  output logic        rx_complete_o,
  output logic        adapter_fail_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(SLOTS + 1);

  rx_state_e         state_q;
  logic [PW-1:0]     wr_ptr_q, commit_q, rd_ptr_q;
  logic [LEN_W-1:0]  len_q, rd_cnt_q;
  logic              ovr_q, sovr_q, und_q;

  logic [CW-1:0]     pkt_cnt;
  logic [LEN_W-1:0]  top_len, remaining, cur_len;
  logic [CODE_W-1:0] top_code;
  logic [PW-1:0]     base;
  logic              have_pkt, start, start_ok, in_pkt, full;
  logic              take, lost, refuse, push;
  logic              do_read, do_disc, bad_read;

  assign have_pkt  = pkt_cnt != '0;
  assign remaining = top_len - rd_cnt_q;
  assign do_disc   = discard_i && have_pkt;
  assign do_read   = rd_en_i && !discard_i && have_pkt && (remaining != '0);
  assign bad_read  = rd_en_i && !discard_i && !(have_pkt && (remaining != '0));

  assign start    = net_valid_i && net_sop_i;
  assign start_ok = (pkt_cnt != CW'(SLOTS)) && !ovr_q;
  assign base     = start ? commit_q : wr_ptr_q;
  assign cur_len  = start ? '0 : len_q;
  // a packet longer than the length field can hold is treated as no room
  assign full     = ((base - rd_ptr_q) == PW'(DEPTH)) || (cur_len == '1);
  assign in_pkt   = start ? start_ok : (state_q == RX_RECV);
  assign take     = net_valid_i && in_pkt && !full;
  assign lost     = net_valid_i && in_pkt && full;
  assign refuse   = start && !start_ok;
  assign push     = take && net_eop_i;

  rxf_byte_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (take),
    .waddr_i (base[AW-1:0]),
    .wdata_i (net_byte_i),
    .raddr_i (rd_ptr_q[AW-1:0]),
    .rdata_o (rd_data_o)
  );

  rxf_pkt_queue #(.SLOTS(SLOTS), .LEN_W(LEN_W), .CODE_W(CODE_W), .CW(CW)) u_q (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (rx_reset_i),
    .push_i      (push && !rx_reset_i),
    .push_len_i  (cur_len + 1'b1),
    .push_code_i (net_err_i),
    .pop_i       (do_disc && !rx_reset_i),
    .count_o     (pkt_cnt),
    .top_len_o   (top_len),
    .top_code_o  (top_code)
  );

  // network side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_IDLE;
      wr_ptr_q <= '0;
      commit_q <= '0;
      len_q    <= '0;
    end else if (rx_reset_i) begin
      state_q  <= RX_IDLE;
      wr_ptr_q <= '0;
      commit_q <= '0;
      len_q    <= '0;
    end else if (take) begin
      wr_ptr_q <= base + 1'b1;
      len_q    <= cur_len + 1'b1;
      if (net_eop_i) begin
        commit_q <= base + 1'b1;
        state_q  <= RX_IDLE;
      end else begin
        state_q  <= RX_RECV;
      end
    end else if (lost || refuse) begin
      wr_ptr_q <= commit_q;
      len_q    <= '0;
      state_q  <= net_eop_i ? RX_IDLE : RX_DROP;
    end else if (net_valid_i && net_eop_i && state_q == RX_DROP) begin
      state_q  <= RX_IDLE;
    end
  end

  // host side and flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      rd_cnt_q <= '0;
      ovr_q    <= 1'b0;
      sovr_q   <= 1'b0;
      und_q    <= 1'b0;
    end else if (rx_reset_i) begin
      rd_ptr_q <= '0;
      rd_cnt_q <= '0;
      ovr_q    <= 1'b0;
      sovr_q   <= 1'b0;
      und_q    <= 1'b0;
    end else begin
      if (do_disc) begin
        rd_ptr_q <= rd_ptr_q + PW'(remaining);
        rd_cnt_q <= '0;
      end else if (do_read) begin
        rd_ptr_q <= rd_ptr_q + 1'b1;
        rd_cnt_q <= rd_cnt_q + 1'b1;
      end
      if (lost)                      ovr_q <= 1'b1;
      else if (do_read || do_disc)   ovr_q <= 1'b0;
      if (refuse && pkt_cnt == CW'(SLOTS)) sovr_q <= 1'b1;
      else if (do_disc)                    sovr_q <= 1'b0;
      if (bad_read) und_q <= 1'b1;
    end
  end

  always_comb begin
    diag_o          = '0;
    diag_o[DG_RECV] = state_q == RX_RECV;
    diag_o[DG_UND]  = und_q;
    diag_o[DG_SOVR] = sovr_q;
    diag_o[DG_OVR]  = ovr_q;
  end

  assign status_o       = have_pkt ? {1'b0, top_code, remaining} : 16'h8000;
  assign rx_complete_o  = have_pkt;
  assign adapter_fail_o = und_q;
endmodule

// File: rtl/rx_pkt_fifo_chk.sv
module rx_pkt_fifo_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_en_i,
  input logic        discard_i,
  input logic        rx_reset_i,
  input logic [15:0] status_o,
  input logic [15:0] diag_o,
  input logic        rx_complete_o,
  input logic        adapter_fail_o
);
  a_r6_underrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diag_o[13] && !rx_reset_i |=> diag_o[13] && adapter_fail_o);

  a_r6_fail_on_empty_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !discard_i && !rx_reset_i && status_o[15] |=> adapter_fail_o);

  a_r9_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_reset_i |=> status_o == 16'h8000 && diag_o == 16'h0000 && !rx_complete_o && !adapter_fail_o);

  a_r2_read_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !discard_i && !rx_reset_i && !status_o[15] && status_o[10:0] != 11'd0
    |=> status_o[10:0] == $past(status_o[10:0]) - 11'd1);

  a_r4_sovr_needs_packets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(diag_o[12]) |-> rx_complete_o);
endmodule

bind rx_pkt_fifo rx_pkt_fifo_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_en_i        (rd_en_i),
  .discard_i      (discard_i),
  .rx_reset_i     (rx_reset_i),
  .status_o       (status_o),
  .diag_o         (diag_o),
  .rx_complete_o  (rx_complete_o),
  .adapter_fail_o (adapter_fail_o)
);

// File: tb/sim_rx_pkt_fifo.sv
module sim_rx_pkt_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nv = 0, sop = 0, eop = 0, rd = 0, disc = 0, rrst = 0;
  logic [7:0]  nb = '0;
  logic [3:0]  ne = '0;
  logic [7:0]  rdat;
  logic [15:0] stat, diag;
  logic        cmpl, fail;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rx_pkt_fifo u0 (
    .clk_i(clk), .rst_ni(rst_n), .net_valid_i(nv), .net_byte_i(nb),
    .net_sop_i(sop), .net_eop_i(eop), .net_err_i(ne), .rd_en_i(rd),
    .discard_i(disc), .rx_reset_i(rrst), .rd_data_o(rdat), .status_o(stat),
    .diag_o(diag), .rx_complete_o(cmpl), .adapter_fail_o(fail)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(int len, logic [3:0] code, logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      nv = 1; nb = seed + 8'(i); sop = (i == 0); eop = (i == len - 1);
      ne = (i == len - 1) ? code : 4'h0;
    end
    @(negedge clk);
    nv = 0; sop = 0; eop = 0; ne = '0;
  endtask

  task automatic read_bytes(int n, logic [7:0] first, string req);
    for (int i = 0; i < n; i++) begin
      chk(req, rdat, first + 8'(i));
      rd = 1;
      @(negedge clk);
    end
    rd = 0;
  endtask

  task automatic pulse_disc();
    disc = 1; @(negedge clk); disc = 0;
  endtask

  task automatic pulse_rrst();
    rrst = 1; @(negedge clk); rrst = 0;
  endtask

  task automatic t_reset();
    chk("R1 empty status", stat, 16'h8000);
    chk("R8 no packet", cmpl, 0);
    chk("R9 diag clear", diag, 0);
    chk("R6 no fail", fail, 0);
  endtask

  task automatic t_single();
    send_pkt(5, 4'h0, 8'h10);
    chk("R1 status clean len5", stat, 16'h0005);
    chk("R8 complete", cmpl, 1);
    read_bytes(3, 8'h10, "R2 data");
    chk("R2 count down", stat, 16'h0002);
    read_bytes(2, 8'h13, "R2 data tail");
    chk("R2 count zero", stat, 16'h0000);
    pulse_disc();
    chk("R7 empty after discard", stat, 16'h8000);
    chk("R8 none left", cmpl, 0);
  endtask

  task automatic t_errcode();
    send_pkt(3, 4'b1101, 8'h40);
    chk("R3 crc code", stat, {1'b0, 4'b1101, 11'd3});
    pulse_disc();
    send_pkt(2, 4'b0010, 8'h50);
    chk("R3 dribble code", stat, {1'b0, 4'b0010, 11'd2});
    pulse_disc();
    pulse_disc();
    chk("R7 discard on empty", stat, 16'h8000);
    chk("R7 discard on empty no fail", diag, 16'h0000);
  endtask

  task automatic t_discard();
    send_pkt(6, 4'h0, 8'h20);
    send_pkt(4, 4'b1000, 8'h80);
    read_bytes(2, 8'h20, "R2 first pkt");
    pulse_disc();
    chk("R7 second becomes top", stat, {1'b0, 4'b1000, 11'd4});
    read_bytes(4, 8'h80, "R7 second data");
    pulse_disc();
    chk("R7 all gone", cmpl, 0);
  endtask

  task automatic t_receiving();
    @(negedge clk); nv = 1; sop = 1; nb = 8'h01;
    @(negedge clk); sop = 0; nb = 8'h02;
    chk("R10 receiving high", diag[15], 1);
    @(negedge clk); eop = 1; nb = 8'h03;
    chk("R10 still receiving", diag[15], 1);
    @(negedge clk); nv = 0; eop = 0;
    chk("R10 receiving low", diag[15], 0);
    chk("R10 pkt stored", stat, 16'h0003);
    pulse_rrst();
  endtask

  task automatic t_statovr();
    for (int k = 0; k < 8; k++) send_pkt(2, 4'h0, 8'(k * 4));
    chk("R4 no flag at eight", diag[12], 0);
    send_pkt(2, 4'h0, 8'hEE);
    chk("R4 status overrun set", diag[12], 1);
    chk("R4 top unchanged", rdat, 8'h00);
    pulse_disc();
    chk("R4 flag clears", diag[12], 0);
    for (int k = 0; k < 6; k++) pulse_disc();
    chk("R4 one left", stat, 16'h0002);
    chk("R4 last is eighth", rdat, 8'd28);
    pulse_disc();
    chk("R4 ninth not stored", stat, 16'h8000);
  endtask

  task automatic t_overrun();
    send_pkt(1500, 4'h0, 8'h00);
    send_pkt(600, 4'h0, 8'h77);
    chk("R5 overrun set", diag[11], 1);
    chk("R5 first intact", stat, 16'd1500);
    send_pkt(3, 4'h0, 8'h99);
    chk("R5 refused while set", stat, 16'd1500);
    read_bytes(1, 8'h00, "R5 read");
    chk("R5 overrun clears", diag[11], 0);
    chk("R5 count", stat, 16'd1499);
    pulse_disc();
    chk("R5 nothing stored", stat, 16'h8000);
    send_pkt(4, 4'h0, 8'h33);
    chk("R5 accepts again", stat, 16'd4);
    chk("R5 data after wrap", rdat, 8'h33);
    pulse_rrst();
  endtask

  task automatic t_underrun();
    rd = 1; @(negedge clk); rd = 0;
    chk("R6 underrun empty", diag[13], 1);
    chk("R6 fail", fail, 1);
    send_pkt(2, 4'h0, 8'h60);
    pulse_disc();
    chk("R6 sticky", fail, 1);
    send_pkt(3, 4'b1011, 8'h61);
    pulse_rrst();
    chk("R9 status cleared", stat, 16'h8000);
    chk("R9 diag cleared", diag, 0);
    chk("R9 fail cleared", fail, 0);
    send_pkt(1, 4'h0, 8'h5A);
    read_bytes(1, 8'h5A, "R6 single byte");
    chk("R6 no fail yet", fail, 0);
    rd = 1; @(negedge clk); rd = 0;
    chk("R6 past end", fail, 1);
    pulse_rrst();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_single();
    t_errcode();
    t_discard();
    t_receiving();
    t_statovr();
    t_overrun();
    t_underrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule